// File: doc/BRIEF.md
# Enclave-Aware Shared Cache Tag and Way-Ownership Controller

This block holds the tag lookup, replacement choice and way-ownership bookkeeping of a shared 16-way set-associative last-level cache in which every line belongs to an enclave. Each line stores a 4-bit owner identifier next to its tag. A lookup hits only when the valid bit, the tag and the owner all match. A miss then places the tag in a victim way. The victim is drawn by a free-running pseudo-random generator, and the draw is confined to the ways that the requester may use.

Each identifier may hold a set of exclusively owned ways and has one of two modes. In the basic mode, lookups may hit in any way. The requester may replace lines of other enclaves, but never in ways that another enclave holds exclusively. In the strict mode, both hits and victims are confined to the enclave's own exclusive ways. Ways are granted from a free-way vector, and each enclave has a cap on how many it may hold. Releasing an enclave's ways returns them to the free vector and invalidates every line stored in them. The data array and the refill path sit outside this block.

Every operation is presented for one cycle on `op_i`. Its response appears on the `rsp_*` outputs after the next rising clock edge. State changes take effect at that same edge.

Top module: `encl_llc_ctrl`

## Requirements
- R1: After reset every line is invalid, all 16 ways are free, and every identifier is in basic mode with no ways. An idle operation (`op_i`=0) gives `rsp_valid_o`=0. Every other code gives `rsp_valid_o`=1 one cycle later. The codes are lookup=1, allocate=2 and release=3.
- R2: A lookup hits only on a valid line in the addressed set whose tag and owner both equal the request. When several lines match, the lowest-numbered way is reported. A hit gives `rsp_hit_o`=1, `rsp_err_o`=0 and `rsp_way_o` equal to the way.
- R3: For an identifier in strict mode, a lookup hits only in ways that the identifier holds exclusively. A matching line in any other way reads as a miss.
- R4: On a strict-mode miss the victim is one of the requester's own exclusive ways. If it holds none, the response is `rsp_err_o`=1 and nothing is written.
- R5: On a basic-mode miss the victim is never a way held exclusively by another identifier. If no way is eligible, the response is `rsp_err_o`=1 and nothing is written.
- R6: A miss with an eligible victim writes the tag and the requester's identifier as a valid line into the reported way (`rsp_way_o`, `rsp_hit_o`=0, `rsp_err_o`=0). A repeated identical lookup then hits in that way.
- R7: The victim is the first eligible way found by scanning upward, with wrap-around, from a start index taken from a free-running linear feedback shift register.
- R8: An allocate request for `cnt_i` ways succeeds when `cnt_i` is at least 1, at least `cnt_i` ways are free, and the identifier's holding plus `cnt_i` stays at or below MAX_EXCL (default 8). The grant is the `cnt_i` lowest-numbered free ways and is reported on `rsp_mask_o` (bit n = way n). The identifier's mode becomes `strict_i`.
- R9: A failing allocate gives `rsp_err_o`=1 and `rsp_mask_o`=0, and it changes no way, mode or free state.
- R10: A release returns all of the identifier's exclusive ways to the free vector, reports them on `rsp_mask_o`, puts the identifier back in basic mode and invalidates every line in those ways in all sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 0 idle, 1 lookup, 2 allocate, 3 release |
| id_i | input | 4 | Requesting enclave identifier |
| set_i | input | SET_W | Set index for a lookup |
| tag_i | input | TAG_W | Tag for a lookup |
| cnt_i | input | 5 | Number of ways to allocate |
| strict_i | input | 1 | Mode written on a successful allocate (1 = strict) |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_err_o | output | 1 | No eligible victim, or allocate refused |
| rsp_way_o | output | 4 | Hit way or filled victim way |
| rsp_mask_o | output | 16 | Ways granted by an allocate or returned by a release |

## Verification
A corrupted ownership table shows at the ports in the cycle after the next allocate or release of an affected identifier, because the granted or returned way mask would differ. A corrupted table also shows on the next miss, as a victim outside the eligible ways. A corrupted tag or owner field shows as a wrong hit, miss or way on the next lookup of that set. Failed allocations are followed by further allocations whose grants expose any state they should not have touched. Invalidation after a release shows at the next lookup of a line that lived in a returned way.

// File: rtl/encl_llc_pkg.sv
package encl_llc_pkg;
    localparam int WAYS  = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int ID_W  = 4;
    localparam int NIDS  = 1 << ID_W;
    localparam int CNT_W = $clog2(WAYS + 1);

    typedef logic [WAYS-1:0]  way_mask_t;
    typedef logic [WAY_W-1:0] way_idx_t;
    typedef logic [ID_W-1:0]  encl_id_t;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_ALLOC  = 2'd2,
        OP_FREE   = 2'd3
    } op_e;

    typedef struct packed {
        logic      valid;
        logic      hit;
        logic      err;
        way_idx_t  way;
        way_mask_t mask;
    } rsp_t;

    function automatic logic [CNT_W-1:0] popcnt(input way_mask_t m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < WAYS; i++) n = n + CNT_W'(m[i]);
        return n;
    endfunction

    // n lowest set bits of m
    function automatic way_mask_t lowest_n(input way_mask_t m, input logic [CNT_W-1:0] n);
        way_mask_t        r;
        logic [CNT_W-1:0] taken;
        r = '0;
        taken = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (m[i] && taken < n) begin
                r[i]  = 1'b1;
                taken = taken + 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/encl_way_table.sv
module encl_way_table
    import encl_llc_pkg::*;
#(
    parameter int MAX_EXCL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  encl_id_t         id,
    input  logic [CNT_W-1:0] cnt,
    input  logic             strict_in,
    output way_mask_t        excl_o,
    output way_mask_t        own_o,
    output logic             strict_o,
    output logic             alloc_ok_o,
    output way_mask_t        grant_o
);
    way_mask_t free_q, excl_q;
    encl_id_t  way_owner_q [WAYS];
    way_mask_t idmask_q    [NIDS];
    logic      mode_q      [NIDS];

    logic [CNT_W-1:0] held;

    always_comb begin
        own_o      = idmask_q[id];
        strict_o   = mode_q[id];
        excl_o     = excl_q;
        held       = popcnt(idmask_q[id]);
        grant_o    = lowest_n(free_q, cnt);
        alloc_ok_o = (cnt != '0) && (popcnt(free_q) >= cnt)
                     && ((int'(held) + int'(cnt)) <= MAX_EXCL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
            excl_q <= '0;
            for (int w = 0; w < WAYS; w++) way_owner_q[w] <= '0;
            for (int i = 0; i < NIDS; i++) begin
                idmask_q[i] <= '0;
                mode_q[i]   <= 1'b0;
            end
        end else if (op == OP_ALLOC && alloc_ok_o) begin
            free_q       <= free_q & ~grant_o;
            excl_q       <= excl_q | grant_o;
            idmask_q[id] <= idmask_q[id] | grant_o;
            mode_q[id]   <= strict_in;
            for (int w = 0; w < WAYS; w++)
                if (grant_o[w]) way_owner_q[w] <= id;
        end else if (op == OP_FREE) begin
            free_q       <= free_q | idmask_q[id];
            excl_q       <= excl_q & ~idmask_q[id];
            idmask_q[id] <= '0;
            mode_q[id]   <= 1'b0;
        end
    end

    // R8/R9: the free vector is the exact complement of the exclusive flags
    a_r8_free_vs_excl: assert property (@(posedge clk) disable iff (rst)
        free_q == ~excl_q);

    // R9: a refused allocation leaves the ownership state unchanged
    a_r9_refused_stable: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ALLOC && !alloc_ok_o) |=> ($stable(excl_q) && $stable(free_q)));

    // R10: a release leaves the identifier with no ways
    a_r10_release_empty: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FREE) |=> (idmask_q[$past(id)] == '0));

    genvar gw, gi;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_way_chk
            logic [NIDS-1:0] col;
            always_comb for (int i = 0; i < NIDS; i++) col[i] = idmask_q[i][gw];
            // R8: a way belongs to at most one identifier, the one recorded as owner
            a_r8_single_owner: assert property (@(posedge clk) disable iff (rst)
                $onehot0(col) && (excl_q[gw] == (col != '0)));
            a_r8_owner_field: assert property (@(posedge clk) disable iff (rst)
                excl_q[gw] |-> idmask_q[way_owner_q[gw]][gw]);
        end
        for (gi = 0; gi < NIDS; gi++) begin : g_id_chk
            // R8: holding never exceeds the cap
            a_r8_cap: assert property (@(posedge clk) disable iff (rst)
                int'(popcnt(idmask_q[gi])) <= MAX_EXCL);
        end
    endgenerate
endmodule

// File: rtl/encl_victim_pick.sv
module encl_victim_pick
    import encl_llc_pkg::*;
#(
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic      clk,
    input  logic      rst,
    input  way_mask_t allow,
    output logic      found_o,
    output way_idx_t  way_o
);
    logic [LFSR_W-1:0] lfsr_q;
    way_idx_t          start;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_SEED[LFSR_W-1:0];
        else     lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]}
                           ^ (lfsr_q[0] ? LFSR_TAPS[LFSR_W-1:0] : '0);
    end

    assign start = lfsr_q[WAY_W-1:0];

    // first allowed way at or above start, wrapping
    always_comb begin
        found_o = 1'b0;
        way_o   = '0;
        for (int k = 0; k < WAYS; k++) begin
            way_idx_t cand;
            cand = start + way_idx_t'(k);
            if (!found_o && allow[cand]) begin
                found_o = 1'b1;
                way_o   = cand;
            end
        end
    end

    // R7: the pick lies in the allowed set whenever that set is non-empty
    a_r7_pick_allowed: assert property (@(posedge clk) disable iff (rst)
        (allow != '0) |-> (found_o && allow[way_o]));
    a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/encl_tag_store.sv
module encl_tag_store
    import encl_llc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    input  encl_id_t         id_i,
    input  way_mask_t        hit_mask,
    input  logic             fill_en,
    input  way_idx_t         fill_way,
    input  logic             inval_en,
    input  way_mask_t        inval_mask,
    output logic             hit_o,
    output way_idx_t         hit_way_o
);
    way_mask_t        valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    encl_id_t         own_q   [SETS][WAYS];

    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit_o && hit_mask[w] && valid_q[set_i][w]
                && tag_q[set_i][w] == tag_i && own_q[set_i][w] == id_i) begin
                hit_o     = 1'b1;
                hit_way_o = way_idx_t'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    own_q[s][w] <= '0;
                end
            end
        end else if (inval_en) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= valid_q[s] & ~inval_mask;
        end else if (fill_en) begin
            valid_q[set_i][fill_way] <= 1'b1;
            tag_q[set_i][fill_way]   <= tag_i;
            own_q[set_i][fill_way]   <= id_i;
        end
    end

    // R6: a filled line is valid with the requested tag and owner next cycle
    a_r6_fill_written: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(set_i)][$past(fill_way)]
                     && tag_q[$past(set_i)][$past(fill_way)] == $past(tag_i)
                     && own_q[$past(set_i)][$past(fill_way)] == $past(id_i)));
    // R10: invalidated ways hold no valid line in the set just looked at
    a_r10_inval: assert property (@(posedge clk) disable iff (rst)
        inval_en |=> ((valid_q[set_i] & $past(inval_mask)) == '0));
endmodule

// File: rtl/encl_llc_ctrl.sv
module encl_llc_ctrl
    import encl_llc_pkg::*;
#(
    parameter int SETS     = 16,
    parameter int TAG_W    = 8,
    parameter int MAX_EXCL = 8,
    localparam int SET_W   = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [3:0]       id_i,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [4:0]       cnt_i,
    input  logic             strict_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_err_o,
    output logic [3:0]       rsp_way_o,
    output logic [15:0]      rsp_mask_o
);
    op_e       op;
    way_mask_t excl, own, grant, hit_mask, vic_mask;
    logic      strict, alloc_ok, hit, vic_found, fill;
    way_idx_t  hit_way, vic_way;
    rsp_t      rsp_q;

    assign op = op_e'(op_i);

    encl_way_table #(.MAX_EXCL(MAX_EXCL)) u_table (
        .clk(clk), .rst(rst), .op(op), .id(id_i), .cnt(cnt_i), .strict_in(strict_i),
        .excl_o(excl), .own_o(own), .strict_o(strict), .alloc_ok_o(alloc_ok), .grant_o(grant)
    );

    // strict confines to own ways; basic excludes others' exclusive ways
    assign hit_mask = strict ? own : '1;
    assign vic_mask = strict ? own : ~(excl & ~own);

    encl_victim_pick u_pick (
        .clk(clk), .rst(rst), .allow(vic_mask), .found_o(vic_found), .way_o(vic_way)
    );

    assign fill = (op == OP_LOOKUP) && !hit && vic_found;

    encl_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .set_i(set_i), .tag_i(tag_i), .id_i(id_i),
        .hit_mask(hit_mask), .fill_en(fill), .fill_way(vic_way),
        .inval_en(op == OP_FREE), .inval_mask(own),
        .hit_o(hit), .hit_way_o(hit_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= (op != OP_IDLE);
            rsp_q.hit   <= (op == OP_LOOKUP) && hit;
            rsp_q.err   <= ((op == OP_LOOKUP) && !hit && !vic_found)
                           || ((op == OP_ALLOC) && !alloc_ok);
            rsp_q.way   <= hit ? hit_way : vic_way;
            unique case (op)
                OP_ALLOC: rsp_q.mask <= alloc_ok ? grant : '0;
                OP_FREE:  rsp_q.mask <= own;
                default:  rsp_q.mask <= '0;
            endcase
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_err_o   = rsp_q.err;
    assign rsp_way_o   = rsp_q.way;
    assign rsp_mask_o  = rsp_q.mask;

    // R4: strict-mode fills land in the requester's own ways
    a_r4_strict_victim: assert property (@(posedge clk) disable iff (rst)
        (fill && strict) |-> own[vic_way]);
    // R5: basic-mode fills never land in another identifier's exclusive way
    a_r5_basic_victim: assert property (@(posedge clk) disable iff (rst)
        (fill && !strict) |-> !(excl[vic_way] && !own[vic_way]));
    // R3: a strict-mode hit is in an own way
    a_r3_strict_hit: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_LOOKUP) && hit && strict) |-> own[hit_way]);
    // R1: idle cycles produce no response
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> !rsp_valid_o);
endmodule

// File: tb/encl_llc_ctrl_bench.sv
module encl_llc_ctrl_bench;
    localparam int SETS = 16, TAG_W = 8, MAX_EXCL = 8, WAYS = 16, NIDS = 16;
    localparam int SET_W = $clog2(SETS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] op_i = 2'd0;
    logic [3:0] id_i = '0;
    logic [SET_W-1:0] set_i = '0;
    logic [TAG_W-1:0] tag_i = '0;
    logic [4:0] cnt_i = '0;
    logic strict_i = 1'b0;
    logic rsp_valid_o, rsp_hit_o, rsp_err_o;
    logic [3:0] rsp_way_o;
    logic [15:0] rsp_mask_o;

    always #2 clk = ~clk;   // 250 MHz

    encl_llc_ctrl #(.SETS(SETS), .TAG_W(TAG_W), .MAX_EXCL(MAX_EXCL)) u_encl_llc_ctrl (
        .clk(clk), .rst(rst), .op_i(op_i), .id_i(id_i), .set_i(set_i), .tag_i(tag_i),
        .cnt_i(cnt_i), .strict_i(strict_i), .rsp_valid_o(rsp_valid_o),
        .rsp_hit_o(rsp_hit_o), .rsp_err_o(rsp_err_o), .rsp_way_o(rsp_way_o),
        .rsp_mask_o(rsp_mask_o)
    );

    int checks = 0, failures = 0;

    // reference model
    logic [TAG_W-1:0] m_tag [SETS][WAYS];
    bit               m_val [SETS][WAYS];
    bit   [3:0]       m_own [SETS][WAYS];
    bit   [15:0]      m_free;
    bit   [15:0]      m_idm [NIDS];
    bit               m_strict [NIDS];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_tag[s][w] = '0; m_own[s][w] = '0;
            end
        m_free = '1;
        for (int i = 0; i < NIDS; i++) begin m_idm[i] = '0; m_strict[i] = 0; end
    endtask

    function automatic int popc(input bit [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += m[i];
        return n;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [3:0] id,
                         input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t,
                         input logic [4:0] c, input logic st);
        op_i = op; id_i = id; set_i = s; tag_i = t; cnt_i = c; strict_i = st;
        @(posedge clk);
        @(negedge clk);
        op_i = 2'd0;
    endtask

    task automatic do_lookup(input logic [3:0] id, input logic [SET_W-1:0] s,
                             input logic [TAG_W-1:0] t, output bit hit, output int way);
        bit [15:0] hm, allow;
        int  ew;
        bit  eh;
        hm    = m_strict[id] ? m_idm[id] : 16'hFFFF;
        allow = m_strict[id] ? m_idm[id] : ~(~m_free & ~m_idm[id]);
        eh = 0; ew = 0;
        for (int w = 0; w < WAYS; w++)
            if (!eh && hm[w] && m_val[s][w] && m_tag[s][w] == t && m_own[s][w] == id) begin
                eh = 1; ew = w;
            end
        issue(2'd1, id, s, t, 5'd0, 1'b0);
        check(rsp_valid_o == 1'b1, "R1", "lookup valid", rsp_valid_o, 1);
        check(rsp_hit_o == eh, m_strict[id] ? "R3" : "R2", "hit", rsp_hit_o, eh);
        if (eh) begin
            check(rsp_way_o == ew[3:0], "R2", "hit way", rsp_way_o, ew);
            check(rsp_err_o == 1'b0, "R2", "hit err", rsp_err_o, 0);
        end else if (allow == '0) begin
            check(rsp_err_o == 1'b1, m_strict[id] ? "R4" : "R5", "no victim err", rsp_err_o, 1);
        end else begin
            check(rsp_err_o == 1'b0, "R6", "fill err", rsp_err_o, 0);
            check(allow[rsp_way_o] == 1'b1, m_strict[id] ? "R4" : "R5",
                  "victim eligible", rsp_way_o, allow);
            if (!rsp_hit_o && !rsp_err_o) begin
                m_val[s][rsp_way_o] = 1; m_tag[s][rsp_way_o] = t; m_own[s][rsp_way_o] = id;
            end
        end
        hit = rsp_hit_o; way = int'(rsp_way_o);
    endtask

    task automatic do_alloc(input logic [3:0] id, input logic [4:0] c, input logic st);
        bit [15:0] g;
        bit ok;
        int taken = 0;
        ok = (c != 0) && (popc(m_free) >= c) && (popc(m_idm[id]) + c <= MAX_EXCL);
        g = '0;
        for (int w = 0; w < WAYS; w++)
            if (m_free[w] && taken < c) begin g[w] = 1; taken++; end
        if (!ok) g = '0;
        issue(2'd2, id, '0, '0, c, st);
        check(rsp_err_o == !ok, ok ? "R8" : "R9", "alloc err", rsp_err_o, !ok);
        check(rsp_mask_o == g, ok ? "R8" : "R9", "alloc mask", rsp_mask_o, g);
        if (ok) begin
            m_free &= ~g; m_idm[id] |= g; m_strict[id] = st;
        end
    endtask

    task automatic do_free(input logic [3:0] id);
        bit [15:0] r;
        r = m_idm[id];
        issue(2'd3, id, '0, '0, 5'd0, 1'b0);
        check(rsp_mask_o == r, "R10", "release mask", rsp_mask_o, r);
        m_free |= r; m_idm[id] = '0; m_strict[id] = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) if (r[w]) m_val[s][w] = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        bit h, h2;
        int w, w2;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid_o == 1'b0, "R1", "idle valid", rsp_valid_o, 0);
        do_lookup(4'd1, 3, 8'h21, h, w);
        check(h == 0, "R1", "first lookup miss", h, 0);
        // R6: same lookup now hits in the filled way
        do_lookup(4'd1, 3, 8'h21, h2, w2);
        check(h2 == 1 && w2 == w, "R6", "refill hit way", w2, w);
        // R2: owner mismatch misses
        do_lookup(4'd2, 3, 8'h21, h, w2);
        check(h == 0, "R2", "owner mismatch", h, 0);
        // R8/R9 corner cases
        do_alloc(4'd5, 5'd0, 1'b0);           // zero count refused
        do_alloc(4'd5, 5'd8, 1'b1);           // ways 0..7
        do_alloc(4'd5, 5'd1, 1'b1);           // over cap
        do_alloc(4'd6, 5'd8, 1'b1);           // ways 8..15
        do_alloc(4'd7, 5'd1, 1'b0);           // none free
        // R4: strict id without ways has no victim; R5: basic id sees all ways excluded
        do_lookup(4'd9, 0, 8'h01, h, w);
        do_alloc(4'd9, 5'd1, 1'b1);
        do_lookup(4'd9, 0, 8'h01, h, w);
        // R3/R4: strict owner fills and hits inside its ways
        do_lookup(4'd5, 1, 8'h44, h, w);
        do_lookup(4'd5, 1, 8'h44, h, w);
        // R10: release invalidates
        do_free(4'd5);
        do_lookup(4'd5, 1, 8'h44, h, w);
        do_free(4'd6);
        do_free(4'd7);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            logic [3:0] id = 4'($urandom_range(0, 3));
            if (r < 80)
                do_lookup(id, SET_W'($urandom_range(0, 3)), TAG_W'($urandom_range(0, 5)), h, w);
            else if (r < 92)
                do_alloc(id, 5'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
            else if (r < 98)
                do_free(id);
            else begin
                issue(2'd0, id, '0, '0, 5'd0, 1'b0);
                check(rsp_valid_o == 1'b0, "R1", "idle no response", rsp_valid_o, 0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule